// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer

This block holds two 8-bit up-counters, channel 0 and channel 1. Each has a control register, a status register, a count register and a compare register. Each channel picks its clock from a shared free-running prescaler: stopped, divide by 8, divide by 64 or divide by 8192. When the count reaches the compare value, the channel raises a match flag and applies a chosen action to its own compare output pin. When the count rolls over, it raises a wrap flag.

One clock-select code, 3'b100, joins the two channels. Written into channel 0, it gives a 16-bit counter: channel 0 is the upper byte and channel 1 is the lower byte, clocked by channel 1's select. Written into channel 1 only, it makes channel 1 count the match events of channel 0. Software reaches all registers through a synchronous register port. A read returns its data one cycle after the address is presented.

Top module: `cascade_timer_pair`

## Requirements
- R1: After reset, every register reads zero, both compare pins are low and reg_rdata is zero. Address bit 2 selects the channel. Address bits 1:0 select the register: 0 control, 1 status, 2 count, 3 compare. Control bits 2:0 hold the clock select and bits 4:3 the pin action; its other bits read 0. Status bit 0 is the match flag and bit 1 is the wrap flag.
- R2: reg_rdata shows, one cycle after an address is driven, the register value as it stood when that address was presented.
- R3: A prescaler starts at zero when reset is released. Clock select 000 stops the counter. Selects 001, 010 and 011 advance it by one every 8, 64 and 8192 clock cycles, on the cycles where the prescaler's low 3, 6 or 13 bits are all ones. Codes 101 to 111 stop the counter.
- R4: An increment from 0xFF to 0x00 sets the channel's wrap flag on the same edge.
- R5: When an increment brings the count equal to the compare value, the match flag sets and the pin action is applied on that edge. Pin actions: 00 keep, 01 drive low, 10 drive high, 11 toggle.
- R6: Writing 0 to a status bit clears it and writing 1 leaves it alone. A hardware set on the same edge as a clearing write wins.
- R7: Select 100 in channel 0 forms a 16-bit counter, whether or not channel 1 also holds 100. Channel 0 is the upper byte and channel 1 the lower byte. The lower byte counts on channel 1's select (100 there means stopped). The upper byte increments on the same edge, and only when the lower byte wraps.
- R8: In 16-bit mode, channel 0's match flag and pin act only when both bytes equal {compare0, compare1}. Channel 1's match flag and pin act when the lower byte equals compare1. Channel 0's wrap flag marks a 0xFFFF to 0x0000 rollover.
- R9: Select 100 in channel 1 with any other select in channel 0 makes channel 1 advance by one on the same edge as each channel 0 match.
- R11: A software write to a count register takes priority over an increment on the same edge, and a written value equal to the compare value sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address: bit 2 channel, bits 1:0 register |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| cmp_out | output | 2 | Compare output pins, bit k for channel k |

## Verification
A wrong prescaler tap or a wrong carry gating shows as a count off by one or more at the very next register read after the timer is stopped. The bench stops the timers at tick-aligned points so that each increment is accounted for. A wrong match qualifier in 16-bit mode shows within the same tick as a wrong pin level or a flag in the wrong channel. A wrong priority between a flag set and a flag clear shows at the next status read. The bench places the clearing write exactly on a tick edge that produces a match.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
    localparam int CW    = 8;
    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_STOP = 3'b000;
    localparam logic [SEL_W-1:0] SEL_LINK = 3'b100;

    localparam logic [1:0] RG_CTRL = 2'd0;
    localparam logic [1:0] RG_STAT = 2'd1;
    localparam logic [1:0] RG_CNT  = 2'd2;
    localparam logic [1:0] RG_CMP  = 2'd3;

    typedef enum logic [1:0] {
        PIN_KEEP = 2'b00,
        PIN_LOW  = 2'b01,
        PIN_HIGH = 2'b10,
        PIN_FLIP = 2'b11
    } pin_act_e;

    typedef enum logic [1:0] {
        LINK_NONE  = 2'd0,
        LINK_WIDE  = 2'd1,
        LINK_EVENT = 2'd2
    } link_e;
endpackage

// File: rtl/ctmr_prescale.sv
module ctmr_prescale #(
    parameter int LOG_A = 3,
    parameter int LOG_B = 6,
    parameter int LOG_C = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [3:0] tick
);
    localparam int PRE_W = LOG_C;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pre = st_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick[0] = 1'b0;
    for (genvar k = 1; k < 4; k++) begin : g_tap
        localparam int L = (k == 1) ? LOG_A : (k == 2) ? LOG_B : LOG_C;
        assign tick[k] = &st_q.pre[L-1:0];
    end
endmodule

// File: rtl/ctmr_link.sv
module ctmr_link
    import ctmr_pkg::*;
(
    input  logic [3:0]       tick,
    input  logic [SEL_W-1:0] sel0,
    input  logic [SEL_W-1:0] sel1,
    input  logic [CW-1:0]    cnt0,
    input  logic [CW-1:0]    cnt1,
    input  logic [CW-1:0]    cmp0,
    input  logic [CW-1:0]    cmp1,
    output link_e            mode,
    output logic             adv0,
    output logic             adv1,
    output logic             hit0,
    output logic             hit1,
    output logic             wrap0,
    output logic             wrap1
);
    logic          clk_en0, clk_en1;
    logic [CW-1:0] nxt0, nxt1, up_val;

    function automatic logic pick_tick(input logic [SEL_W-1:0] s, input logic [3:0] t);
        return s[SEL_W-1] ? 1'b0 : t[s[1:0]];
    endfunction

    always_comb begin
        if (sel0 == SEL_LINK)      mode = LINK_WIDE;
        else if (sel1 == SEL_LINK) mode = LINK_EVENT;
        else                       mode = LINK_NONE;

        clk_en0 = pick_tick(sel0, tick);
        clk_en1 = pick_tick(sel1, tick);
        nxt0    = cnt0 + 1'b1;
        nxt1    = cnt1 + 1'b1;
        up_val  = cnt0;

        adv0 = clk_en0;
        adv1 = clk_en1;
        hit0 = 1'b0;
        hit1 = 1'b0;

        unique case (mode)
            LINK_WIDE: begin
                adv1   = clk_en1;
                adv0   = clk_en1 && (cnt1 == '1);
                up_val = adv0 ? nxt0 : cnt0;
                hit1   = adv1 && (nxt1 == cmp1);
                hit0   = adv1 && (up_val == cmp0) && (nxt1 == cmp1);
            end
            LINK_EVENT: begin
                adv0 = clk_en0;
                hit0 = adv0 && (nxt0 == cmp0);
                adv1 = hit0;
                hit1 = adv1 && (nxt1 == cmp1);
            end
            default: begin
                hit0 = adv0 && (nxt0 == cmp0);
                hit1 = adv1 && (nxt1 == cmp1);
            end
        endcase

        wrap0 = adv0 && (cnt0 == '1);
        wrap1 = adv1 && (cnt1 == '1);
    end
endmodule

// File: rtl/ctmr_chan.sv
module ctmr_chan
    import ctmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_reg,
    input  logic [CW-1:0]    wr_data,
    input  logic [1:0]       rd_reg,
    input  logic             adv,
    input  logic             hit,
    input  logic             wrap,
    output logic [SEL_W-1:0] sel,
    output pin_act_e         act,
    output logic [CW-1:0]    cnt,
    output logic [CW-1:0]    cmp,
    output logic             flag_hit,
    output logic             flag_wrap,
    output logic             pin,
    output logic [CW-1:0]    rd_val
);
    localparam int ACT_LO = SEL_W;
    localparam int PAD_W  = CW - SEL_W - 2;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        pin_act_e         act;
        logic             f_hit;
        logic             f_wrap;
        logic [CW-1:0]    cnt;
        logic [CW-1:0]    cmp;
        logic             pin;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) st_d.cnt = st_q.cnt + 1'b1;

        if (wr_en) begin
            unique case (wr_reg)
                RG_CTRL: begin
                    st_d.sel = wr_data[SEL_W-1:0];
                    st_d.act = pin_act_e'(wr_data[ACT_LO+1:ACT_LO]);
                end
                RG_STAT: begin
                    st_d.f_hit  = st_q.f_hit  & wr_data[0];
                    st_d.f_wrap = st_q.f_wrap & wr_data[1];
                end
                RG_CNT:  st_d.cnt = wr_data;
                default: st_d.cmp = wr_data;
            endcase
        end

        if (hit) begin
            st_d.f_hit = 1'b1;
            unique case (st_q.act)
                PIN_LOW:  st_d.pin = 1'b0;
                PIN_HIGH: st_d.pin = 1'b1;
                PIN_FLIP: st_d.pin = ~st_q.pin;
                default:  st_d.pin = st_q.pin;
            endcase
        end
        if (wrap) st_d.f_wrap = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (rd_reg)
            RG_CTRL: rd_val = {{PAD_W{1'b0}}, st_q.act, st_q.sel};
            RG_STAT: rd_val = {{(CW-2){1'b0}}, st_q.f_wrap, st_q.f_hit};
            RG_CNT:  rd_val = st_q.cnt;
            default: rd_val = st_q.cmp;
        endcase
    end

    assign sel       = st_q.sel;
    assign act       = st_q.act;
    assign cnt       = st_q.cnt;
    assign cmp       = st_q.cmp;
    assign flag_hit  = st_q.f_hit;
    assign flag_wrap = st_q.f_wrap;
    assign pin       = st_q.pin;

    assert_wrap_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag_wrap);

    assert_hit_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_hit);

    assert_pin_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == PIN_HIGH) |=> pin);

    assert_pin_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == PIN_LOW) |=> !pin);
endmodule

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair
    import ctmr_pkg::*;
#(
    parameter int DIV_A_LOG = 3,
    parameter int DIV_B_LOG = 6,
    parameter int DIV_C_LOG = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    reg_addr,
    input  logic          reg_we,
    input  logic [CW-1:0] reg_wdata,
    output logic [CW-1:0] reg_rdata,
    output logic [1:0]    cmp_out
);
    localparam int NCH = 2;

    typedef struct packed {
        logic [CW-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [3:0]                 tick;
    logic [NCH-1:0][SEL_W-1:0]  sel_v;
    logic [NCH-1:0][CW-1:0]     cnt_v, cmp_v, rd_v;
    pin_act_e                   act_v [NCH];
    logic [NCH-1:0]             adv_v, hit_v, wrap_v, fhit_v, fwrap_v;
    link_e                      mode;

    ctmr_prescale #(
        .LOG_A(DIV_A_LOG),
        .LOG_B(DIV_B_LOG),
        .LOG_C(DIV_C_LOG)
    ) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    ctmr_link u_link (
        .tick (tick),
        .sel0 (sel_v[0]),
        .sel1 (sel_v[1]),
        .cnt0 (cnt_v[0]),
        .cnt1 (cnt_v[1]),
        .cmp0 (cmp_v[0]),
        .cmp1 (cmp_v[1]),
        .mode (mode),
        .adv0 (adv_v[0]),
        .adv1 (adv_v[1]),
        .hit0 (hit_v[0]),
        .hit1 (hit_v[1]),
        .wrap0(wrap_v[0]),
        .wrap1(wrap_v[1])
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        ctmr_chan u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_we && (reg_addr[2] == 1'(k))),
            .wr_reg   (reg_addr[1:0]),
            .wr_data  (reg_wdata),
            .rd_reg   (reg_addr[1:0]),
            .adv      (adv_v[k]),
            .hit      (hit_v[k]),
            .wrap     (wrap_v[k]),
            .sel      (sel_v[k]),
            .act      (act_v[k]),
            .cnt      (cnt_v[k]),
            .cmp      (cmp_v[k]),
            .flag_hit (fhit_v[k]),
            .flag_wrap(fwrap_v[k]),
            .pin      (cmp_out[k]),
            .rd_val   (rd_v[k])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.rdata = rd_v[reg_addr[2]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;

    assert_upper_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LINK_WIDE && cnt_v[1] != '1 && !(reg_we && reg_addr == 3'b010))
        |=> $stable(cnt_v[0]));

    assert_wide_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LINK_WIDE && hit_v[0] && !reg_we)
        |=> (cnt_v[0] == cmp_v[0] && cnt_v[1] == cmp_v[1]));

    assert_event_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LINK_EVENT && hit_v[0] && !(reg_we && reg_addr == 3'b110))
        |=> (cnt_v[1] == $past(cnt_v[1]) + 1'b1));

    assert_wrap_seen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_v[1] && !(reg_we && reg_addr == 3'b110)) |=> (cnt_v[1] == '0));
endmodule

// File: tb/tb_cascade_timer_pair.sv
module tb_cascade_timer_pair;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] reg_addr;
    logic       reg_we;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [1:0] cmp_out;

    int          total = 0;
    int          bad = 0;
    int unsigned cyc = 0;
    logic        pend = 1'b0;
    logic        done = 1'b0;
    logic [7:0]  exp_q [$];
    string       tag_q [$];

    cascade_timer_pair dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_we   (reg_we),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .cmp_out  (cmp_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst_n) cyc <= cyc + 1;
        else       cyc <= 0;
    end

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        reg_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        pend = 1'b1;
        @(negedge clk);
        pend = 1'b0;
    endtask

    task automatic wait_ticks(input int n, input int div);
        int left = n;
        while (left > 0) begin
            @(negedge clk);
            if (((cyc - 1) % div) == div - 1) left--;
        end
    endtask

    task automatic align_tick8();
        while ((cyc % 8) != 7) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (pend) begin
                logic [7:0] e;
                string      t;
                #1;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(reg_rdata, e, t);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        chk({6'd0, cmp_out}, 8'h00, "R1 pins after reset");
        chk(reg_rdata, 8'h00, "R1 rdata after reset");
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, "R1 register reset value");

        wr(3'd3, 8'h5A);
        rd(3'd3, 8'h5A, "R2 read after write");

        // R3 R4: divide by 8 through a rollover
        wr(3'd2, 8'hFD); wr(3'd3, 8'h10); wr(3'd0, 8'h11);
        wait_ticks(4, 8);
        wr(3'd0, 8'h10);
        rd(3'd2, 8'h01, "R3 count after 4 ticks of /8");
        rd(3'd1, 8'h02, "R4 wrap flag only");
        chk({6'd0, cmp_out}, 8'h00, "R5 no match no pin change");
        rd(3'd0, 8'h10, "R1 control readback");
        repeat (40) @(negedge clk);
        rd(3'd2, 8'h01, "R3 stopped count holds");

        wr(3'd6, 8'h00); wr(3'd4, 8'h02);
        wait_ticks(3, 64);
        wr(3'd4, 8'h00);
        rd(3'd6, 8'h03, "R3 divide by 64");
        wr(3'd4, 8'h05);
        repeat (100) @(negedge clk);
        wr(3'd4, 8'h00);
        rd(3'd6, 8'h03, "R3 reserved select stops");
        wr(3'd4, 8'h03);
        wait_ticks(1, 8192);
        wr(3'd4, 8'h00);
        rd(3'd6, 8'h04, "R3 divide by 8192");

        // R5 match and pin actions
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h0E); wr(3'd0, 8'h11);
        wait_ticks(2, 8);
        wr(3'd0, 8'h10);
        rd(3'd2, 8'h10, "R5 count at compare");
        rd(3'd1, 8'h01, "R5 match flag");
        chk({7'd0, cmp_out[0]}, 8'h01, "R5 drive high");
        wr(3'd2, 8'h0F); wr(3'd0, 8'h19); wait_ticks(1, 8); wr(3'd0, 8'h18);
        chk({7'd0, cmp_out[0]}, 8'h00, "R5 toggle to low");
        wr(3'd2, 8'h0F); wr(3'd0, 8'h19); wait_ticks(1, 8); wr(3'd0, 8'h18);
        chk({7'd0, cmp_out[0]}, 8'h01, "R5 toggle to high");
        wr(3'd2, 8'h0F); wr(3'd0, 8'h01); wait_ticks(1, 8); wr(3'd0, 8'h00);
        chk({7'd0, cmp_out[0]}, 8'h01, "R5 keep action");
        wr(3'd2, 8'h0F); wr(3'd0, 8'h09); wait_ticks(1, 8); wr(3'd0, 8'h08);
        chk({7'd0, cmp_out[0]}, 8'h00, "R5 drive low");

        // R6 flag clearing
        wr(3'd1, 8'h01);
        rd(3'd1, 8'h01, "R6 writing one keeps flag");
        wr(3'd1, 8'h00);
        rd(3'd1, 8'h00, "R6 writing zero clears");
        wr(3'd2, 8'h0E); wr(3'd0, 8'h01);
        wait_ticks(2, 8);
        wr(3'd2, 8'h0F);
        align_tick8();
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h00);
        rd(3'd1, 8'h01, "R6 hardware set wins over clear");
        rd(3'd2, 8'h10, "R6 count at that edge");

        // R11 write priority
        wr(3'd0, 8'h01);
        align_tick8();
        wr(3'd2, 8'h40);
        wr(3'd0, 8'h00);
        rd(3'd2, 8'h40, "R11 write beats increment");
        wr(3'd1, 8'h00); wr(3'd2, 8'h10);
        rd(3'd1, 8'h00, "R11 written compare value sets no flag");

        // R7 R8 16-bit mode
        wr(3'd5, 8'h00);
        wr(3'd2, 8'h00); wr(3'd3, 8'h01); wr(3'd6, 8'hFE); wr(3'd7, 8'h02);
        wr(3'd0, 8'h14); wr(3'd4, 8'h19);
        wait_ticks(4, 8);
        wr(3'd4, 8'h18);
        rd(3'd2, 8'h01, "R7 upper byte carried once");
        rd(3'd6, 8'h02, "R7 lower byte");
        rd(3'd1, 8'h01, "R8 full match flag");
        rd(3'd5, 8'h03, "R8 lower match and wrap");
        chk({6'd0, cmp_out}, 8'h03, "R8 both pins acted");

        wr(3'd1, 8'h00); wr(3'd5, 8'h00); wr(3'd2, 8'h00); wr(3'd6, 8'h00);
        wr(3'd4, 8'h19);
        wait_ticks(2, 8);
        wr(3'd4, 8'h18);
        rd(3'd6, 8'h02, "R7 lower counts");
        rd(3'd2, 8'h00, "R7 upper holds without carry");
        rd(3'd5, 8'h01, "R8 lower-only match");
        rd(3'd1, 8'h00, "R8 no upper match on lower-only");
        chk({6'd0, cmp_out}, 8'h01, "R8 only lower pin toggled");

        wr(3'd1, 8'h00); wr(3'd5, 8'h00); wr(3'd2, 8'hFF); wr(3'd6, 8'hFF);
        wr(3'd4, 8'h19);
        wait_ticks(1, 8);
        wr(3'd4, 8'h18);
        rd(3'd2, 8'h00, "R7 upper wraps");
        rd(3'd6, 8'h00, "R7 lower wraps");
        rd(3'd1, 8'h02, "R8 16-bit wrap flag");
        rd(3'd5, 8'h02, "R4 lower wrap flag");

        wr(3'd4, 8'h04);
        repeat (64) @(negedge clk);
        rd(3'd6, 8'h00, "R7 both linked lower stopped");
        rd(3'd2, 8'h00, "R7 both linked upper stopped");
        wr(3'd4, 8'h00);

        // R9 event counting
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00); wr(3'd5, 8'h00);
        wr(3'd2, 8'h00); wr(3'd3, 8'h03); wr(3'd6, 8'h05); wr(3'd7, 8'h06);
        wr(3'd4, 8'h14); wr(3'd0, 8'h01);
        wait_ticks(3, 8);
        wr(3'd0, 8'h00);
        rd(3'd2, 8'h03, "R9 lower channel reached compare");
        rd(3'd6, 8'h06, "R9 event counted");
        rd(3'd5, 8'h01, "R9 event channel matched");
        chk({7'd0, cmp_out[1]}, 8'h01, "R9 event channel pin high");
        wr(3'd0, 8'h01);
        wait_ticks(256, 8);
        wr(3'd0, 8'h00);
        rd(3'd2, 8'h03, "R9 source back at compare");
        rd(3'd6, 8'h07, "R9 exactly one more event");
        rd(3'd1, 8'h03, "R4 source match and wrap flags");

        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule